// File: doc/BRIEF.md
# Tick-Accurate Clock Glitch Generator

This block produces the clock for a target system from one fast reference clock. It normally runs a steady base tick, four of which make one machine cycle of the target. A one-cycle arm strobe marks the moment the target leaves reset. The block then counts base ticks from that point. When the count reaches a programmed offset, it replaces that tick, or a run of consecutive ticks, with much shorter ticks at one of two selectable fast rates. After the replaced ticks it returns to the base rate.

Every tick is a whole number of reference cycles: high for half of its period, low for the rest. The period is switched only at a tick boundary, so a change between base and fast ticks cannot produce a runt pulse. After the replaced ticks a completion flag goes high. It stays high, and no further glitch is produced, until the next arm strobe. The offset, the length and the rate are captured at the arm strobe.

Top module: `glitch_clock_gen`

## Requirements
- R1: While reset is asserted, `tclk_o` and `done_o` are both low.
- R2: A base tick lasts 90 reference cycles: `tclk_o` is high for 45 cycles and then low for 45 cycles.
- R3: Until the first arm strobe, every tick is a base tick and `done_o` stays low.
- R4: Ticks are numbered from 0. Tick 0 is the first tick whose rising edge follows the clock edge that samples `arm_i`. The tick whose number equals `offset_i` is the first fast tick, and every tick before it is a base tick.
- R5: Exactly `len_i`+1 consecutive ticks are fast ticks. The ticks after them are base ticks.
- R6: With `speed_i`=0 a fast tick lasts 12 cycles (6 high, 6 low). With `speed_i`=1 it lasts 10 cycles (5 high, 5 low).
- R7: The arm strobe clears `done_o`. `done_o` rises at the rising edge of the first base tick after the fast ticks and then stays high until the next arm strobe.
- R8: After the fast ticks, every tick remains a base tick until the block is armed again.
- R9: `offset_i`, `len_i` and `speed_i` take effect only at the arm strobe. Changing them afterwards alters no tick.
- R10: Every tick begins with a rising edge, and no tick is shorter than the fastest allowed period, so neither the high nor the low phase is ever a runt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle strobe: target reset release, starts tick counting |
| offset_i | input | 24 | Number of the first tick to replace |
| len_i | input | 8 | Number of replaced ticks minus one |
| speed_i | input | 1 | Fast rate select: 0 = 12-cycle tick, 1 = 10-cycle tick |
| tclk_o | output | 1 | Clock to the target |
| done_o | output | 1 | High once the glitch has been delivered |

## Verification
Both outputs are registered, so `tclk_o` and `done_o` change one reference edge after the decision that drives them. The bench therefore reads them on the falling edge that follows that edge. A rising edge of `tclk_o` that appears on the same edge that samples `arm_i` is not counted as a tick. Tick periods and high times are measured in falling edges, from one observed rise to the next. The expected value of `done_o` is checked at every observed rise: it must be high from the rise of tick `offset_i`+`len_i`+1 onward and low at every earlier rise.

// File: rtl/glitch_gen_pkg.sv
`timescale 1ns/1ps
package glitch_gen_pkg;
    localparam int unsigned CNT_W_DEF = 24;
    localparam int unsigned LEN_W_DEF = 8;
    localparam int unsigned PER_W_DEF = 8;
    localparam int unsigned BASE_PER_DEF = 90;
    localparam int unsigned FAST_SLOW_DEF = 12;
    localparam int unsigned FAST_QUICK_DEF = 10;

    typedef enum logic {
        SPEED_SLOW  = 1'b0,
        SPEED_QUICK = 1'b1
    } glitch_speed_e;
endpackage

// File: rtl/glitch_tick_shaper.sv
`timescale 1ns/1ps
module glitch_tick_shaper #(
    parameter int unsigned PER_W    = 8,
    parameter int unsigned BASE_PER = 90,
    parameter int unsigned MIN_PER  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] next_per_i,
    output logic             tick_end_o,
    output logic             tclk_o
);
    typedef struct packed {
        logic [PER_W-1:0] ph;
        logic [PER_W-1:0] per;
        logic             tclk;
    } shp_t;

    shp_t shp_d, shp_q;

    always_comb begin
        shp_d = shp_q;
        tick_end_o = (shp_q.ph == shp_q.per - PER_W'(1));
        if (tick_end_o) begin
            shp_d.ph  = '0;
            shp_d.per = next_per_i;
        end else begin
            shp_d.ph = shp_q.ph + PER_W'(1);
        end
        shp_d.tclk = (shp_d.ph < (shp_d.per >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shp_q.ph   <= PER_W'(BASE_PER - 1);
            shp_q.per  <= PER_W'(BASE_PER);
            shp_q.tclk <= 1'b0;
        end else begin
            shp_q <= shp_d;
        end
    end

    assign tclk_o = shp_q.tclk;

    // R2: the output only rises at the first cycle of a tick
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shp_q.tclk) |-> (shp_q.ph == '0));

    // R10: a tick boundary never loads a period short enough to make a runt
    p_min_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_end_o |-> (next_per_i >= PER_W'(MIN_PER)));
endmodule

// File: rtl/glitch_sequencer.sv
`timescale 1ns/1ps
module glitch_sequencer
    import glitch_gen_pkg::*;
#(
    parameter int unsigned CNT_W      = 24,
    parameter int unsigned LEN_W      = 8,
    parameter int unsigned PER_W      = 8,
    parameter int unsigned BASE_PER   = 90,
    parameter int unsigned FAST_SLOW  = 12,
    parameter int unsigned FAST_QUICK = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             speed_i,
    input  logic             tick_end_i,
    output logic [PER_W-1:0] next_per_o,
    output logic             done_o
);
    localparam int unsigned IDX_W = CNT_W + 1;

    typedef struct packed {
        logic             armed;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] stop;
        logic [PER_W-1:0] fper;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_window;

    always_comb begin
        seq_d = seq_q;
        in_window = seq_q.armed && !seq_q.done &&
                    (seq_q.idx >= seq_q.first) && (seq_q.idx < seq_q.stop);
        next_per_o = in_window ? seq_q.fper : PER_W'(BASE_PER);

        if (arm_i) begin
            seq_d.armed = 1'b1;
            seq_d.done  = 1'b0;
            seq_d.idx   = '0;
            seq_d.first = IDX_W'(offset_i);
            seq_d.stop  = IDX_W'(offset_i) + IDX_W'(len_i) + IDX_W'(1);
            seq_d.fper  = (glitch_speed_e'(speed_i) == SPEED_QUICK)
                          ? PER_W'(FAST_QUICK) : PER_W'(FAST_SLOW);
        end else if (tick_end_i && seq_q.armed && !seq_q.done) begin
            if (seq_q.idx == seq_q.stop) begin
                seq_d.done  = 1'b1;
                seq_d.armed = 1'b0;
            end else begin
                seq_d.idx = seq_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done_o = seq_q.done;

    // R7: done only rises on a tick boundary
    p_done_on_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.done) |-> $past(tick_end_i));

    // R7: done holds until the next arm strobe
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.done && !arm_i) |=> seq_q.done);

    // R7: arming clears done and restarts the count
    p_arm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!seq_q.done && seq_q.idx == '0));

    // R3 / R8: without an active arm the tick count does not move
    p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.armed && !arm_i) |=> $stable(seq_q.idx));
endmodule

// File: rtl/glitch_clock_gen.sv
`timescale 1ns/1ps
module glitch_clock_gen
    import glitch_gen_pkg::*;
#(
    parameter int unsigned CNT_W      = CNT_W_DEF,
    parameter int unsigned LEN_W      = LEN_W_DEF,
    parameter int unsigned PER_W      = PER_W_DEF,
    parameter int unsigned BASE_PER   = BASE_PER_DEF,
    parameter int unsigned FAST_SLOW  = FAST_SLOW_DEF,
    parameter int unsigned FAST_QUICK = FAST_QUICK_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             speed_i,
    output logic             tclk_o,
    output logic             done_o
);
    localparam int unsigned MIN_PER = (FAST_QUICK < FAST_SLOW) ? FAST_QUICK : FAST_SLOW;

    logic [PER_W-1:0] next_per;
    logic             tick_end;

    glitch_sequencer #(
        .CNT_W(CNT_W), .LEN_W(LEN_W), .PER_W(PER_W), .BASE_PER(BASE_PER),
        .FAST_SLOW(FAST_SLOW), .FAST_QUICK(FAST_QUICK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .offset_i(offset_i),
        .len_i(len_i), .speed_i(speed_i), .tick_end_i(tick_end),
        .next_per_o(next_per), .done_o(done_o)
    );

    glitch_tick_shaper #(
        .PER_W(PER_W), .BASE_PER(BASE_PER), .MIN_PER(MIN_PER)
    ) u_shaper (
        .clk(clk), .rst_n(rst_n), .next_per_i(next_per),
        .tick_end_o(tick_end), .tclk_o(tclk_o)
    );
endmodule

// File: tb/glitch_clock_gen_bench.sv
`timescale 1ns/1ps
module glitch_clock_gen_bench;
    localparam int BASE = 90;
    localparam int NV = 5;
    localparam int V_OFF  [NV] = '{0, 1, 3, 4, 2};
    localparam int V_LEN  [NV] = '{0, 0, 2, 1, 3};
    localparam int V_SPD  [NV] = '{0, 1, 0, 1, 1};
    localparam int V_FPER [NV] = '{12, 10, 12, 10, 10};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm_i = 1'b0;
    logic [23:0] offset_i = '0;
    logic [7:0]  len_i = '0;
    logic        speed_i = 1'b0;
    logic        tclk_o, done_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    glitch_clock_gen u_glitch_clock_gen (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .offset_i(offset_i),
        .len_i(len_i), .speed_i(speed_i), .tclk_o(tclk_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watch ntick whole ticks; ticks first..last (inclusive) expected fast with period fper.
    task automatic watch(input int ntick, input int first, input int last, input int fper,
                         input int done_from);
        int idx = -1;
        int per = 0;
        int hi = 0;
        int exp_per;
        logic prev = tclk_o;
        while (idx < ntick) begin
            @(negedge clk);
            if (tclk_o && !prev) begin
                if (idx >= 0) begin
                    exp_per = (idx >= first && idx <= last) ? fper : BASE;
                    if (idx < first)
                        chk(per == exp_per && hi == exp_per/2, "R4 tick before window", per, exp_per);
                    else if (idx <= last)
                        chk(per == exp_per && hi == exp_per/2, "R5/R6 fast tick", per*100+hi, exp_per*100+exp_per/2);
                    else
                        chk(per == exp_per && hi == exp_per/2, "R8 base after glitch", per, exp_per);
                end
                idx++;
                per = 1;
                hi = 1;
                if (idx < ntick)
                    chk(done_o == (idx >= done_from), "R7 done at tick rise", done_o, int'(idx >= done_from));
            end else begin
                per++;
                if (tclk_o) hi++;
            end
            prev = tclk_o;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tclk_o == 1'b0, "R1 tclk in reset", tclk_o, 0);
        chk(done_o == 1'b0, "R1 done in reset", done_o, 0);
        rst_n = 1'b1;

        // R2 / R3: free-running base ticks before any arm, no done
        watch(4, 1000, 999, BASE, 1000);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            offset_i = 24'(V_OFF[v]);
            len_i = 8'(V_LEN[v]);
            speed_i = V_SPD[v][0];
            arm_i = 1'b1;
            @(negedge clk);
            arm_i = 1'b0;
            // R9: scramble the setup inputs after the strobe
            offset_i = 24'(V_OFF[v] + 9);
            len_i = 8'd6;
            speed_i = ~V_SPD[v][0];
            chk(done_o == 1'b0, "R7 done cleared by arm", done_o, 0);
            watch(V_OFF[v] + V_LEN[v] + 5, V_OFF[v], V_OFF[v] + V_LEN[v], V_FPER[v],
                  V_OFF[v] + V_LEN[v] + 1);
        end

        // R8 / R9: long quiet stretch after the last glitch stays base, done held
        offset_i = 24'd0;
        len_i = 8'd0;
        watch(6, 1000, 999, BASE, 0);

        // R10 / R2: reset mid-run, then a glitch on the very first tick
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tclk_o == 1'b0 && done_o == 1'b0, "R1 reset mid-run", {tclk_o, done_o}, 0);
        rst_n = 1'b1;
        offset_i = 24'd0;
        len_i = 8'd1;
        speed_i = 1'b1;
        arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        watch(5, 0, 1, 10, 2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule